// File: doc/BRIEF.md
# DVS Voltage Step Sequencer

This block produces the setting code that a buck regulator's reference DAC follows. It holds no registers of its own. Software supplies two setting codes, a default and an alternate, and two control inputs: a scaling enable and a select line. While scaling is off, the target is always the default code. While scaling is on, the select line picks between the two codes.

When the effective selection changes, the block does not jump to the new code. It walks the DAC code toward the new target one step at a time, passing through every value in between. Each step waits for a programmable number of clock cycles, so the slew rate is fixed. For the whole of such a walk it raises a fault-blanking output that masks the over-voltage and under-voltage detectors. On a downward walk it also enables a light-load pull-down, so the output voltage keeps pace with the falling code. A direct rewrite of the currently active code is not treated as a selection change: the DAC code jumps straight to the new value and faults stay unmasked. While the regulator's on input is low, the block enables the output discharge path.

Top module: `dvs_ramp_seq`

## Requirements
- R1: After reset, `dac_code` equals `code_dflt`, and `flt_blank`, `pulldn_en` and `dischg_en` are all 0.
- R2: While `scale_en` is 0, the target is `code_dflt`. Toggling `sel_alt` then has no effect: `dac_code` stays at `code_dflt` and `flt_blank` stays 0.
- R3: The effective selection is `scale_en & sel_alt`. When it changes on clock edge E0 and the new target differs from `dac_code`, the code moves by exactly one step toward the target on edges E0+k*(`step_div`+1), for k = 1, 2, and so on, and it passes through every intermediate value.
- R4: `flt_blank` is 1 from edge E0 up to the edge on which `dac_code` reaches the target, and it falls on that same edge.
- R5: `pulldn_en` is 1 only while `flt_blank` is 1 and the target is below `dac_code`. It falls on the same edge as `flt_blank`. An upward walk never raises it.
- R6: When no walk is in progress, a change to the value of the active setting code appears on `dac_code` one edge later, and `flt_blank` stays 0.
- R7: A selection change during a walk continues from the current code without a jump. The step counter restarts, and `pulldn_en` follows the new direction from edge E0 on.
- R8: While `reg_on` is 0, `dischg_en` is 1 from the next edge on. The same edge aborts any walk: `flt_blank` and `pulldn_en` go to 0 and `dac_code` loads the target. Once `reg_on` returns to 1, `dischg_en` clears on the next edge.
- R9: A selection change whose new target equals the current `dac_code` starts no walk, and `flt_blank` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_on | input | 1 | Regulator enabled |
| scale_en | input | 1 | Voltage scaling active |
| sel_alt | input | 1 | Selects the alternate code when scaling is active |
| code_dflt | input | CODE_W | Default setting code |
| code_alt | input | CODE_W | Alternate setting code |
| step_div | input | DIV_W | Clock cycles per step, minus one |
| dac_code | output | CODE_W | Code driven to the reference DAC |
| flt_blank | output | 1 | Masks over- and under-voltage faults during a walk |
| pulldn_en | output | 1 | Light-load pull-down enable during downward walks |
| dischg_en | output | 1 | Output discharge enable while disabled |

## Verification
The bench builds the block with CODE_W = 6 and DIV_W = 4. The short code range keeps the walks short, so full walks of up to ten steps fit in a few hundred cycles, and every intermediate code can be compared one by one. The small divider width lets the bench run with a step period of one, two and three cycles. This exercises the step schedule at the back-to-back rate and with idle cycles between steps. It also covers a reversal in mid-walk, where the counter restart decides when the first step after the turn lands.

// File: rtl/dvs_pkg.sv
// Package: shared types for the DVS step sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dvs_pkg;

    // Direction of the next code step.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/dvs_target_sel.sv
// Module: dvs_target_sel
// Picks the target code from the default and alternate codes. It flags a
// change of the effective selection (scaling enable AND select) for exactly
// one cycle.
// Assumes: a synchronous active-low reset; after reset the selection is
// treated as "default".
module dvs_target_sel #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scale_en,
    input  logic              sel_alt,
    input  logic [CODE_W-1:0] code_dflt,
    input  logic [CODE_W-1:0] code_alt,
    output logic [CODE_W-1:0] tgt_code,
    output logic              sel_chg
);

    logic eff_sel;
    logic sel_q;

    // Form the effective selection and the target code.
    always_comb begin
        eff_sel  = scale_en & sel_alt;
        tgt_code = eff_sel ? code_alt : code_dflt;
        sel_chg  = eff_sel ^ sel_q;
    end

    // Remember the selection last seen, to detect its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= eff_sel;
    end

    AST_NO_SEL_WITHOUT_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (!scale_en && !$past(scale_en) && !$past(sel_chg)) |-> !sel_chg); // R2

endmodule

// File: rtl/dvs_step_tick.sv
// Module: dvs_step_tick
// Step-period prescaler. It raises tick once every div+1 enabled cycles. A
// clear input restarts the count, so the first tick after a clear comes
// div+1 cycles later.
// Assumes: div may change at any time; a count at or above div ticks at once.
module dvs_step_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Decode the tick from the running count.
    always_comb begin
        tick = !clr && (cnt_q >= div);
    end

    // Advance the count; restart it on a clear or a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr | tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    AST_TICK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && div != '0) |=> !tick); // R3

endmodule

// File: rtl/dvs_code_stepper.sv
// Module: dvs_code_stepper
// Holds the DAC code and the walk state. A selection change starts a walk.
// During a walk the code moves one step per tick toward the target. Outside
// a walk the code follows the target directly. Disabling the regulator
// aborts the walk and raises the discharge enable.
// Assumes: the target and the selection-change flag come from dvs_target_sel.
module dvs_code_stepper
    import dvs_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_on,
    input  logic              sel_chg,
    input  logic              tick,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic [CODE_W-1:0] rst_code,
    output logic [CODE_W-1:0] code_q,
    output logic              ramp_q,
    output logic              pd_q,
    output logic              dis_q
);

    step_dir_e         dir;
    logic [CODE_W-1:0] code_n;
    logic              ramp_n;

    // Choose the step direction from the target and the present code.
    always_comb begin
        if (tgt_code > code_q)      dir = STEP_UP;
        else if (tgt_code < code_q) dir = STEP_DOWN;
        else                        dir = STEP_HOLD;
    end

    // Next code and next walk state.
    always_comb begin
        code_n = code_q;
        ramp_n = 1'b0;
        if (!reg_on) begin
            code_n = tgt_code;
        end else if (sel_chg) begin
            ramp_n = (dir != STEP_HOLD);
        end else if (ramp_q) begin
            if (tick) begin
                case (dir)
                    STEP_UP:   code_n = code_q + 1'b1;
                    STEP_DOWN: code_n = code_q - 1'b1;
                    default:   code_n = code_q;
                endcase
            end
            ramp_n = (code_n != tgt_code);
        end else begin
            code_n = tgt_code;
        end
    end

    // Register the code, the walk flag, the pull-down and the discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= rst_code;
            ramp_q <= 1'b0;
            pd_q   <= 1'b0;
            dis_q  <= 1'b0;
        end else begin
            code_q <= code_n;
            ramp_q <= ramp_n;
            pd_q   <= ramp_n && (tgt_code < code_n);
            dis_q  <= !reg_on;
        end
    end

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_q && $past(ramp_q)) |->
            (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
             code_q == $past(code_q) - 1'b1)); // R3
    AST_PD_NEEDS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |-> ramp_q); // R5
    AST_OFF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_on |=> (dis_q && !ramp_q && !pd_q)); // R8

endmodule

// File: rtl/dvs_ramp_seq.sv
// Module: dvs_ramp_seq (top)
// DVS voltage step sequencer. It combines target selection, the step-period
// prescaler and the code stepper, and drives the DAC code, the fault-blank,
// the pull-down and the discharge enables.
// Assumes: all inputs are synchronous to clk; step_div+1 is the step period
// in cycles.
module dvs_ramp_seq #(
    parameter int CODE_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_on,
    input  logic              scale_en,
    input  logic              sel_alt,
    input  logic [CODE_W-1:0] code_dflt,
    input  logic [CODE_W-1:0] code_alt,
    input  logic [DIV_W-1:0]  step_div,
    output logic [CODE_W-1:0] dac_code,
    output logic              flt_blank,
    output logic              pulldn_en,
    output logic              dischg_en
);

    logic [CODE_W-1:0] tgt_code;
    logic              sel_chg;
    logic              tick;
    logic              tick_clr;
    logic              ramp_q;

    dvs_target_sel #(.CODE_W(CODE_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .scale_en  (scale_en),
        .sel_alt   (sel_alt),
        .code_dflt (code_dflt),
        .code_alt  (code_alt),
        .tgt_code  (tgt_code),
        .sel_chg   (sel_chg)
    );

    // Restart the prescaler when no walk runs or a new one begins.
    always_comb begin
        tick_clr = sel_chg | !ramp_q | !reg_on;
    end

    dvs_step_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .div   (step_div),
        .tick  (tick)
    );

    dvs_code_stepper #(.CODE_W(CODE_W)) u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_on   (reg_on),
        .sel_chg  (sel_chg),
        .tick     (tick),
        .tgt_code (tgt_code),
        .rst_code (code_dflt),
        .code_q   (dac_code),
        .ramp_q   (ramp_q),
        .pd_q     (pulldn_en),
        .dis_q    (dischg_en)
    );

    // The walk flag is the fault-blank output.
    always_comb begin
        flt_blank = ramp_q;
    end

    AST_BLANK_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_blank) |-> $past(reg_on)); // R4

endmodule

// File: tb/sim_dvs_ramp_seq.sv
module sim_dvs_ramp_seq;

    localparam int CW = 6;
    localparam int DW = 4;

    typedef struct {
        int           cyc;
        logic [CW-1:0] code;
        logic         blank;
        logic         pd;
        logic         dis;
        string        req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_on = 1'b1;
    logic          scale_en = 1'b0;
    logic          sel_alt = 1'b0;
    logic [CW-1:0] code_dflt = 6'd20;
    logic [CW-1:0] code_alt = 6'd10;
    logic [DW-1:0] step_div = 4'd2;
    logic [CW-1:0] dac_code;
    logic          flt_blank, pulldn_en, dischg_en;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    dvs_ramp_seq #(.CODE_W(CW), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_on(reg_on), .scale_en(scale_en),
        .sel_alt(sel_alt), .code_dflt(code_dflt), .code_alt(code_alt),
        .step_div(step_div), .dac_code(dac_code), .flt_blank(flt_blank),
        .pulldn_en(pulldn_en), .dischg_en(dischg_en)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: at each falling edge, compare every item due by this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (dac_code !== e.code || flt_blank !== e.blank ||
                pulldn_en !== e.pd || dischg_en !== e.dis) begin
                n_bad++;
                $display("FAIL %s cyc %0d: got code=%0d blank=%b pd=%b dis=%b exp code=%0d blank=%b pd=%b dis=%b",
                         e.req, cyc, dac_code, flt_blank, pulldn_en, dischg_en,
                         e.code, e.blank, e.pd, e.dis);
            end
        end
    end

    task automatic push(int c, int code, bit b, bit p, bit d, string r);
        exp_t e;
        e.cyc = c; e.code = CW'(code); e.blank = b; e.pd = p; e.dis = d; e.req = r;
        sb.push_back(e);
    endtask

    // Wait for the next falling edge, then move off it before driving.
    task automatic step_drv();
        @(negedge clk);
        #1;
    endtask

    // Expected walk from st to tg; the selection change was driven at cycle c.
    task automatic push_walk(int c, int st, int tg, int d, string r);
        int n;
        bit dn;
        dn = tg < st;
        n  = dn ? st - tg : tg - st;
        push(c + 1, st, 1, dn, 0, r);
        for (int i = 1; i <= n; i++) begin
            push(c + 1 + i * (d + 1) - 1, dn ? st - i + 1 : st + i - 1, 1, dn, 0, r);
            push(c + 1 + i * (d + 1), dn ? st - i : st + i, i < n, dn && i < n, 0, r);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step_drv();
    endtask

    // Driver: applies stimulus and queues the expected results.
    initial begin
        int c;
        idle(2);
        rst_n = 1'b1;
        push(cyc, 20, 0, 0, 0, "R1");
        idle(2);

        // R2: scaling off, select toggles ignored
        sel_alt = 1'b1; c = cyc;
        push(c + 1, 20, 0, 0, 0, "R2");
        push(c + 4, 20, 0, 0, 0, "R2");
        idle(5);
        sel_alt = 1'b0;
        idle(2);

        // R3 R4 R5: downward walk 20 -> 10, period 3
        scale_en = 1'b1; sel_alt = 1'b1; c = cyc;
        push_walk(c, 20, 10, 2, "R3");
        idle(40);

        // R3 R4 R5: upward walk 10 -> 20, period 1
        step_div = 4'd0; sel_alt = 1'b0; c = cyc;
        push_walk(c, 10, 20, 0, "R5");
        idle(15);

        // R6: rewrite active default code while idle -> jump, no blank
        code_dflt = 6'd25; c = cyc;
        push(c + 1, 25, 0, 0, 0, "R6");
        idle(3);
        code_dflt = 6'd20;
        push(cyc + 1, 20, 0, 0, 0, "R6");
        idle(3);

        // R7: reverse mid-walk, period 2
        step_div = 4'd1; code_alt = 6'd30; sel_alt = 1'b1; c = cyc;
        push(c + 1, 20, 1, 0, 0, "R7");
        push(c + 3, 21, 1, 0, 0, "R7");
        push(c + 5, 22, 1, 0, 0, "R7");
        push(c + 7, 23, 1, 0, 0, "R7");
        idle(7);
        sel_alt = 1'b0; c = cyc;
        push_walk(c, 23, 20, 1, "R7");
        idle(12);

        // R9: selection change with equal target -> no walk
        code_alt = 6'd20; sel_alt = 1'b1; c = cyc;
        push(c + 1, 20, 0, 0, 0, "R9");
        push(c + 2, 20, 0, 0, 0, "R9");
        idle(4);

        // R8: disable mid-walk aborts, code loads target, discharge on
        step_div = 4'd3; code_alt = 6'd5; sel_alt = 1'b0; idle(1);
        sel_alt = 1'b1; c = cyc;
        push(c + 1, 20, 1, 1, 0, "R8");
        push(c + 5, 19, 1, 1, 0, "R8");
        idle(6);
        reg_on = 1'b0; c = cyc;
        push(c + 1, 5, 0, 0, 1, "R8");
        push(c + 3, 5, 0, 0, 1, "R8");
        idle(4);
        reg_on = 1'b1; c = cyc;
        push(c + 1, 5, 0, 0, 0, "R8");
        idle(4);

        // R1: reset again returns to the default code
        rst_n = 1'b0; c = cyc;
        push(c + 1, 20, 0, 0, 0, "R1");
        idle(2);
        scale_en = 1'b0; sel_alt = 1'b0; rst_n = 1'b1;
        idle(4);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done && sb.size() == 0);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: got %0d pending exp 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule